// File: doc/BRIEF.md
# Shift-Based First-Order Lowpass Smoother

This block smooths a stream of unsigned 8-bit samples with a single-pole recursive lowpass filter. It has no multiplier. The filter weight is set by a compile-time shift amount `SHIFT`, and the effective divisor is `F = 2^SHIFT`.

For each accepted sample, the block forms a signed 16-bit difference between the new input and the stored output. It adds `F/2` to that difference so the division rounds, then divides by shifting right arithmetically by `SHIFT` bits. The resulting increment is added to the stored output, and the sum is clamped to the 8-bit range before it is written back.

With the default `SHIFT = 3`:
- each sample keeps 7/8 of the previous output's distance to the input;
- a step reaches about 63 % of its final value after roughly seven and a half samples.

An optional parameter makes the first sample after reset load the state directly, so the filter does not spend its first samples ramping up from zero. A one-cycle strobe announces every new output value.

Top module: `shift_lowpass`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released, `outSample` is 0x00 and `outValid` is 0.
- R2: When `inValid` is 1 and `PRELOAD` is 0 or a sample was already taken since reset, the new output is `Y + floor((X - Y + F/2) / F)`. Here X is `inSample`, Y is the previous `outSample` and F = 2^SHIFT. The default SHIFT is 3: from Y = 0, an input of 200 gives 25, and an input of 77 gives 10.
- R3: The division for a negative difference rounds toward minus infinity, which is an arithmetic shift. From Y = 25, an input of 0 gives 22. From Y = 200, an input of 0 gives 175. Whenever Y - X > F/2, the output strictly decreases.
- R4: An update never overshoots. The new output lies between the previous output and the input, both included.
- R5: `outValid` is 1 in exactly the cycle after each cycle in which `inValid` was 1, and 0 otherwise. Samples presented on consecutive cycles are each accepted.
- R6: While `inValid` is 0, `outSample` holds its value whatever `inSample` does.
- R7: With `PRELOAD` = 1, the first sample accepted after reset is copied unchanged into the output. Later samples follow R2.
- R8: With a constant input held for 60 samples, the output settles within the rounding dead band. After a rising approach it ends in [X - (F/2 - 1), X]. After a falling approach it ends in [X, X + F/2].
- R9: Full-scale steps between 0x00 and 0xFF never wrap: the sum is clamped to 0..255 before it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inSample` as a new sample this cycle |
| inSample | input | DATA_W | Unsigned input sample |
| outValid | output | 1 | One-cycle strobe: `outSample` was just updated |
| outSample | output | DATA_W | Filtered unsigned output (registered state) |

## Verification
The bench first uses hand-computed single steps (0→200, 25→0, 200→0, 0→77). These show whether the division rounds with the F/2 bias, and whether negative differences floor instead of truncating toward zero.

Long constant runs, rising and then falling, expose the asymmetric dead band left by the rounding. Full-scale 0x00/0xFF steps probe the clamp and the signed width.

A back-to-back pseudo-random stream checks that no sample is dropped and that every strobe lines up. Idle stretches with a toggling input check that unaccepted samples change nothing. A second instance built with preload shows whether the first sample bypasses the filter, both after the initial reset and after a later one.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic loadState;   // apply the filter update to the state
    logic preloadSel;  // copy the raw input into the state
  } lpfStrobes_t;

endpackage

// File: rtl/lpf_ctrl.sv
module lpf_ctrl #(
  parameter bit PRELOAD = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output lpf_pkg::lpfStrobes_t strobes,
  output logic                outValid
);

  logic firstPending;

  // The preload variant needs a flag for the first sample; the plain one does not.
  generate
    if (PRELOAD) begin : gPreload
      logic firstQ;
      always_ff @(posedge clk) begin
        if (rst)          firstQ <= 1'b1;
        else if (inValid) firstQ <= 1'b0;
      end
      assign firstPending = firstQ;
    end else begin : gPlain
      assign firstPending = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes.loadState  = inValid && !firstPending;
    strobes.preloadSel = inValid &&  firstPending;
  end

  // Output strobe trails the accepted sample by exactly one register.
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/lpf_datapath.sv
module lpf_datapath #(
  parameter int DATA_W = 8,
  parameter int DIFF_W = 16,
  parameter int SHIFT  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lpf_pkg::lpfStrobes_t strobes,
  input  logic [DATA_W-1:0]    inSample,
  output logic [DATA_W-1:0]    state
);

  localparam int PAD_W = DIFF_W - DATA_W;
  localparam int FDIV  = 1 << SHIFT;
  localparam logic signed [DIFF_W-1:0] BIAS  = DIFF_W'(FDIV / 2);
  localparam logic signed [DIFF_W-1:0] TOP_S = DIFF_W'((1 << DATA_W) - 1);

  logic signed [DIFF_W-1:0] inExt, stateExt, diff, biased, increment, sumFull;
  logic        [DATA_W-1:0] clamped, nextState, stateQ;

  always_comb begin
    inExt     = $signed({{PAD_W{1'b0}}, inSample});
    stateExt  = $signed({{PAD_W{1'b0}}, stateQ});
    diff      = inExt - stateExt;
    biased    = diff + BIAS;           // half the divisor for rounding
    increment = biased >>> SHIFT;      // floor division by 2^SHIFT
    sumFull   = stateExt + increment;
  end

  // Fold the wide sum back into the sample range.
  always_comb begin
    if (sumFull < 0)          clamped = '0;
    else if (sumFull > TOP_S) clamped = '1;
    else                      clamped = sumFull[DATA_W-1:0];
  end

  always_comb begin
    if (strobes.preloadSel)     nextState = inSample;
    else if (strobes.loadState) nextState = clamped;
    else                        nextState = stateQ;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= nextState;
  end

  assign state = stateQ;

endmodule

// File: rtl/shift_lowpass.sv
module shift_lowpass #(
  parameter int DATA_W  = 8,
  parameter int DIFF_W  = 16,
  parameter int SHIFT   = 3,
  parameter bit PRELOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample
);

  lpf_pkg::lpfStrobes_t strobes;

  lpf_ctrl #(.PRELOAD(PRELOAD)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lpf_datapath #(.DATA_W(DATA_W), .DIFF_W(DIFF_W), .SHIFT(SHIFT)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inSample (inSample),
    .state    (outSample)
  );

endmodule

// File: rtl/lpf_checker.sv
module lpf_checker #(
  parameter int DATA_W  = 8,
  parameter int SHIFT   = 3,
  parameter bit PRELOAD = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] inSample,
  input logic              outValid,
  input logic [DATA_W-1:0] outSample
);

  localparam int HALF     = (1 << SHIFT) / 2;
  localparam int RISE_MIN = (HALF > 0) ? HALF : 1;

  logic seenSample;
  always_ff @(posedge clk) begin
    if (rst)          seenSample <= 1'b0;
    else if (inValid) seenSample <= 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (outSample == '0 && !outValid));

  assert_rise_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && (int'(inSample) - int'(outSample)) >= RISE_MIN) |=> (outSample > $past(outSample)));

  assert_fall_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && (int'(outSample) - int'(inSample)) > HALF) |=> (outSample < $past(outSample)));

  assert_no_overshoot_up_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSample >= outSample) |=> (outSample <= $past(inSample) && outSample >= $past(outSample)));

  assert_no_overshoot_down_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSample < outSample) |=> (outSample >= $past(inSample) && outSample <= $past(outSample)));

  assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_strobe_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outSample));

  assert_preload_R7: assert property (@(posedge clk) disable iff (rst)
    (PRELOAD && !seenSample && inValid) |=> (outSample == $past(inSample)));

endmodule

bind shift_lowpass lpf_checker #(.DATA_W(DATA_W), .SHIFT(SHIFT), .PRELOAD(PRELOAD)) uChk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inSample  (inSample),
  .outValid  (outValid),
  .outSample (outSample)
);

// File: tb/sim_shift_lowpass.sv
module sim_shift_lowpass;

  localparam int DATA_W = 8;
  localparam int SHIFT  = 3;
  localparam int HALF   = (1 << SHIFT) / 2;

  typedef struct {
    int    expVal;
    int    prevVal;
    int    inVal;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inSample = '0;
  logic outValid0, outValid1;
  logic [DATA_W-1:0] outSample0, outSample1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  item_t q0[$];
  item_t q1[$];
  int m0 = 0;
  int m1 = 0;
  bit first1 = 1'b1;
  logic prevIn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  shift_lowpass #(.DATA_W(DATA_W), .SHIFT(SHIFT), .PRELOAD(1'b0)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid0), .outSample(outSample0));

  shift_lowpass #(.DATA_W(DATA_W), .SHIFT(SHIFT), .PRELOAD(1'b1)) u1 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid1), .outSample(outSample1));

  function automatic int stepModel(int y, int x);
    int inc;
    int s;
    inc = (x - y + HALF) >>> SHIFT;
    s = y + inc;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Driver: presents one sample and queues the expected results.
  task automatic sendSample(int x, string req);
    item_t it;
    @(negedge clk);
    inSample = DATA_W'(x);
    inValid  = 1'b1;
    it.prevVal = m0; it.inVal = x; it.req = req;
    m0 = stepModel(m0, x); it.expVal = m0;
    q0.push_back(it);
    it.prevVal = m1;
    m1 = first1 ? x : stepModel(m1, x);
    first1 = 1'b0;
    it.expVal = m1;
    q1.push_back(it);
  endtask

  task automatic idle(int n, bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (toggle) inSample = DATA_W'($urandom_range(0, 255));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    idle(2, 1'b0);
    rst = 1'b0;
    m0 = 0; m1 = 0; first1 = 1'b1;
  endtask

  always @(posedge clk) prevIn <= inValid && !rst;

  // Monitor: compares each strobed output with the queued expectation.
  always @(negedge clk) begin
    item_t it;
    #1;
    if (!rst) begin
      check("R5 strobe u0", int'(outValid0), int'(prevIn));
      check("R5 strobe u1", int'(outValid1), int'(prevIn));
      if (outValid0) begin
        if (q0.size() == 0) check("R5 u0 unexpected strobe", 1, 0);
        else begin
          it = q0.pop_front();
          check({it.req, " u0"}, int'(outSample0), it.expVal);
          checkRange("R4 u0 no overshoot", int'(outSample0),
                     (it.prevVal < it.inVal) ? it.prevVal : it.inVal,
                     (it.prevVal < it.inVal) ? it.inVal : it.prevVal);
        end
      end
      if (outValid1) begin
        if (q1.size() == 0) check("R5 u1 unexpected strobe", 1, 0);
        else begin
          it = q1.pop_front();
          check({it.req, " u1"}, int'(outSample1), it.expVal);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3, 1'b0);
    #2;
    check("R1 reset out u0", int'(outSample0), 0);
    check("R1 reset strobe u0", int'(outValid0), 0);
    check("R1 reset out u1", int'(outSample1), 0);
    rst = 1'b0;
    idle(1, 1'b0);
    #2;
    check("R1 after release u0", int'(outSample0), 0);
    check("R1 after release strobe", int'(outValid0), 0);

    // Hand-computed single steps.
    sendSample(200, "R2 step");
    idle(1, 1'b0);
    #2;
    check("R2 0->200 gives 25", int'(outSample0), 25);
    check("R7 preload first 200", int'(outSample1), 200);
    sendSample(0, "R3 step");
    idle(1, 1'b0);
    #2;
    check("R3 25->0 gives 22", int'(outSample0), 22);
    check("R3 200->0 gives 175", int'(outSample1), 175);

    // Rising settle.
    for (int i = 0; i < 60; i++) sendSample(200, "R8 rise");
    idle(2, 1'b0);
    #2;
    checkRange("R8 rising settle", int'(outSample0), 200 - (HALF - 1), 200);

    // Idle with a changing input.
    idle(8, 1'b1);
    #2;
    check("R6 hold u0", int'(outSample0), m0);
    check("R6 hold u1", int'(outSample1), m1);

    // Falling settle.
    for (int i = 0; i < 60; i++) sendSample(40, "R8 fall");
    idle(2, 1'b0);
    #2;
    checkRange("R8 falling settle", int'(outSample0), 40, 40 + HALF);

    // Full-scale steps.
    for (int i = 0; i < 80; i++) sendSample(255, "R9 full up");
    idle(1, 1'b0);
    #2;
    checkRange("R9 top no wrap", int'(outSample0), 255 - (HALF - 1), 255);
    for (int i = 0; i < 80; i++) sendSample(0, "R9 full down");
    idle(1, 1'b0);
    #2;
    checkRange("R9 bottom no wrap", int'(outSample0), 0, HALF);

    // Back-to-back pseudo-random stream.
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendSample(int'(lfsr[7:0]), "R5 stream");
    end
    idle(3, 1'b0);
    check("R5 all u0 results seen", q0.size(), 0);
    check("R5 all u1 results seen", q1.size(), 0);

    // Second reset: preload again.
    doReset();
    #2;
    check("R1 re-reset u1", int'(outSample1), 0);
    sendSample(77, "R7 reload");
    idle(1, 1'b0);
    #2;
    check("R2 0->77 gives 10", int'(outSample0), 10);
    check("R7 preload 77", int'(outSample1), 77);
    idle(3, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule